// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events from a set of maskable peripheral sources and from one non-maskable source. It presents a single request line to the CPU, together with a vector index that names the winning source. Each maskable source keeps a sticky flag. A flag is raised by a one-cycle event pulse and lowered by a software clear strobe. A flag can raise a request only when its own enable bit and the global enable are both set.

The CPU answers a request with a one-cycle acknowledge. Acceptance does three things. It clears the global enable and remembers the value it had before. It clears the flag of a source marked single-cause, or the non-maskable pending bit. It holds the accepted vector on the output for the cycle after the acknowledge. A multi-cause flag stays set, so the handler can read the flags and find the exact cause. A one-cycle return pulse restores the remembered global enable.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all flags are 0, the non-maskable pending bit is 0, the global enable `gie_o` is 0 and `irq_o` is 0.
- R2: A pulse on `src_evt_i[i]` sets `flags_o[i]` from the next cycle on. A pulse on `src_clr_i[i]` clears it. When both are high in the same cycle, the flag ends up set.
- R3: A set flag whose `src_en_i[i]` is 0 raises no request.
- R4: While `gie_o` is 0 and no non-maskable request is pending, `irq_o` stays 0 whatever the flags and enables are.
- R5: A pulse on `nmi_i` makes a request pending that raises `irq_o` regardless of `gie_o` and `src_en_i`. Its vector is NUM_SRC (8 by default), and it wins over every maskable source.
- R6: Among enabled, set maskable flags, the highest index wins, and `vec_o` equals that index.
- R7: An `ack_i` pulse while `irq_o` is 1 accepts the request. In the cycle after the acknowledge, `irq_o` is 0 and `vec_o` still shows the accepted vector.
- R8: Acceptance clears `gie_o` from the next cycle on.
- R9: A pulse on `reti_i` sets `gie_o` back to the value it had just before the last acceptance.
- R10: On acceptance, the flag of a single-cause source is cleared. Bit i of SINGLE_MASK set means single-cause, and the default 8'h0F makes sources 0 to 3 single-cause. A multi-cause flag stays set. The non-maskable pending bit is cleared.
- R11: A pulse on `gie_wr_i` loads `gie_val_i` into `gie_o` on the next cycle, unless an acceptance or a return happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt_i | input | NUM_SRC | One-cycle event pulses that set the flags |
| src_clr_i | input | NUM_SRC | Software clear strobes for the flags |
| src_en_i | input | NUM_SRC | Per-source enable bits |
| nmi_i | input | 1 | Non-maskable event pulse |
| gie_wr_i | input | 1 | Software write strobe for the global enable |
| gie_val_i | input | 1 | Value written to the global enable |
| ack_i | input | 1 | CPU acknowledge pulse |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Request to the CPU |
| vec_o | output | VEC_W | Vector index of the current or accepted request |
| gie_o | output | 1 | Global interrupt enable |
| flags_o | output | NUM_SRC | Current flag bits |

## Verification
A wrong flag shows on `flags_o` one cycle after the pulse that caused it. Through `vec_o`, it shows in the same cycle as a wrong choice of winner. A fault in the saved-enable bit stays hidden until a return pulse, and then shows on `gie_o` in the next cycle. The bench therefore follows every acceptance with a return and checks the restored value. A wrong automatic clear shows as a flag that is still set, or already gone, in the cycle after the acknowledge. It also shows as a wrong vector after the following return.

// File: rtl/irq_pkg.sv
// Package irq_pkg: types shared by the interrupt controller units.
package irq_pkg;
    // Operation applied to the global enable in one cycle.
    typedef enum logic [1:0] {
        GIE_HOLD   = 2'd0,
        GIE_TAKE   = 2'd1,
        GIE_RETURN = 2'd2,
        GIE_WRITE  = 2'd3
    } gie_op_e;
endpackage

// File: rtl/irq_flag_bank.sv
// irq_flag_bank: sticky per-source flags plus the non-maskable pending bit.
// Assumes event, clear and take inputs are one-cycle pulses; set wins over clear.
module irq_flag_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] take_clr_i,
    input  logic               nmi_i,
    input  logic               nmi_take_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               nmi_pend_o
);
    logic [NUM_SRC-1:0] flag_q;
    logic               nmi_q;

    // Update each flag: event set dominates software or acceptance clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= evt_i | (flag_q & ~(clr_i | take_clr_i));
        end
    end

    // Track the non-maskable request until it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
        end else if (nmi_i) begin
            nmi_q <= 1'b1;
        end else if (nmi_take_i) begin
            nmi_q <= 1'b0;
        end
    end

    assign flags_o    = flag_q;
    assign nmi_pend_o = nmi_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flag_q[g]);
        assert_single_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (take_clr_i[g] && !evt_i[g]) |=> !flag_q[g]);
    end
endmodule

// File: rtl/irq_prio_enc.sv
// irq_prio_enc: picks the winning request; non-maskable first, then highest index.
// Assumes requests are already gated by enables.
module irq_prio_enc #(
    parameter int NUM_SRC = 8,
    localparam int VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               nmi_i,
    output logic               any_o,
    output logic               is_nmi_o,
    output logic [VEC_W-1:0]   vec_o
);
    // Scan upward so the highest set index is the last assignment that sticks.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i]) vec_o = VEC_W'(i);
        end
        if (nmi_i) vec_o = VEC_W'(NUM_SRC);
        any_o    = nmi_i | (|req_i);
        is_nmi_o = nmi_i;
    end
endmodule

// File: rtl/irq_gie_ctl.sv
// irq_gie_ctl: global enable with a one-deep save of its value at acceptance.
// Assumes take outranks return, which outranks software write.
module irq_gie_ctl
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic reti_i,
    input  logic wr_i,
    input  logic wval_i,
    output logic gie_o
);
    gie_op_e op;
    logic    gie_q;
    logic    save_q;

    // Resolve the operation for this cycle by priority.
    always_comb begin
        if (take_i)      op = GIE_TAKE;
        else if (reti_i) op = GIE_RETURN;
        else if (wr_i)   op = GIE_WRITE;
        else             op = GIE_HOLD;
    end

    // Apply the operation to the enable and its saved copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            save_q <= 1'b0;
        end else begin
            case (op)
                GIE_TAKE:   begin save_q <= gie_q; gie_q <= 1'b0; end
                GIE_RETURN: gie_q <= save_q;
                GIE_WRITE:  gie_q <= wval_i;
                default:    gie_q <= gie_q;
            endcase
        end
    end

    assign gie_o = gie_q;

    assert_take_clears_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !gie_q);
    assert_reti_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !take_i) |=> (gie_q == $past(save_q)));
endmodule

// File: rtl/irq_vec_ctrl.sv
// irq_vec_ctrl: top of the prioritized vectored interrupt controller.
// Assumes ack_i and reti_i are one-cycle pulses from the CPU side.
module irq_vec_ctrl #(
    parameter int                 NUM_SRC     = 8,
    parameter logic [NUM_SRC-1:0] SINGLE_MASK = 8'h0F,
    localparam int                VEC_W       = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt_i,
    input  logic [NUM_SRC-1:0] src_clr_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               nmi_i,
    input  logic               gie_wr_i,
    input  logic               gie_val_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               gie_o,
    output logic [NUM_SRC-1:0] flags_o
);
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] take_clr;
    logic               nmi_pend;
    logic               any_req;
    logic               win_nmi;
    logic [VEC_W-1:0]   win_vec;
    logic               accept;
    logic               ack_d;
    logic [VEC_W-1:0]   held_q;
    logic               gie;

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (src_evt_i),
        .clr_i      (src_clr_i),
        .take_clr_i (take_clr),
        .nmi_i      (nmi_i),
        .nmi_take_i (accept && win_nmi),
        .flags_o    (flags),
        .nmi_pend_o (nmi_pend)
    );

    // Gate flags by their own enable and the global enable.
    assign req = flags & src_en_i & {NUM_SRC{gie}};

    irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .req_i    (req),
        .nmi_i    (nmi_pend),
        .any_o    (any_req),
        .is_nmi_o (win_nmi),
        .vec_o    (win_vec)
    );

    irq_gie_ctl u_gie (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (accept),
        .reti_i (reti_i),
        .wr_i   (gie_wr_i),
        .wval_i (gie_val_i),
        .gie_o  (gie)
    );

    // Per-source acceptance clear, only for single-cause sources.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_take
        assign take_clr[g] = accept && !win_nmi && SINGLE_MASK[g] &&
                             (win_vec == VEC_W'(g));
    end

    assign irq_o  = any_req && !ack_d;
    assign accept = ack_i && irq_o;

    // Remember the acknowledge and the accepted vector for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d  <= 1'b0;
            held_q <= '0;
        end else begin
            ack_d <= accept;
            if (accept) held_q <= win_vec;
        end
    end

    assign vec_o   = ack_d ? held_q : win_vec;
    assign gie_o   = gie;
    assign flags_o = flags;

    assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (vec_o == $past(vec_o)) && !irq_o);
    assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && !nmi_pend) |-> !irq_o);
    assert_nmi_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !ack_d) |-> (irq_o && vec_o == VEC_W'(NUM_SRC)));
    assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_pend && ((flags & src_en_i) == '0)) |-> !irq_o);
endmodule

// File: tb/tb_irq_vec_ctrl.sv
// tb_irq_vec_ctrl: directed scenarios, each task checks its own results.
module tb_irq_vec_ctrl;
    localparam int N  = 8;
    localparam int VW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  src_evt, src_clr, src_en;
    logic          nmi, gie_wr, gie_val, ack, reti;
    logic          irq;
    logic [VW-1:0] vec;
    logic          gie;
    logic [N-1:0]  flags;
    int            checks = 0;
    int            errors = 0;

    irq_vec_ctrl #(.NUM_SRC(N), .SINGLE_MASK(8'h0F)) dut (
        .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .src_clr_i(src_clr),
        .src_en_i(src_en), .nmi_i(nmi), .gie_wr_i(gie_wr), .gie_val_i(gie_val),
        .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_o(vec), .gie_o(gie),
        .flags_o(flags)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_evt(input logic [N-1:0] m);
        src_evt = m; step(); src_evt = '0;
    endtask
    task automatic pulse_clr(input logic [N-1:0] m);
        src_clr = m; step(); src_clr = '0;
    endtask
    task automatic write_gie(input logic v);
        gie_wr = 1'b1; gie_val = v; step(); gie_wr = 1'b0;
    endtask
    task automatic do_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", irq, 0);
        chk("R1 gie", gie, 0);
        chk("R1 flags", flags, 0);
    endtask

    task automatic t_flags();
        pulse_evt(8'h20);
        chk("R2 set", flags, 8'h20);
        pulse_clr(8'h20);
        chk("R2 clear", flags, 8'h00);
        src_evt = 8'h02; src_clr = 8'h02; step(); src_evt = '0; src_clr = '0;
        chk("R2 set wins", flags, 8'h02);
        pulse_clr(8'hFF);
    endtask

    task automatic t_gating();
        src_en = 8'hFF;
        pulse_evt(8'h08);
        chk("R4 gie low blocks", irq, 0);
        write_gie(1'b1);
        chk("R11 gie written", gie, 1);
        chk("R6 single req", irq, 1);
        chk("R6 vec", vec, 3);
        src_en = 8'hF7; #1;
        chk("R3 disabled source", irq, 0);
        src_en = 8'hFF; #1;
        pulse_clr(8'hFF);
    endtask

    task automatic t_priority();
        pulse_evt(8'h48);
        chk("R6 highest wins", vec, 6);
        ack = 1'b1; #1;
        chk("R7 vec at ack", vec, 6);
        step(); ack = 1'b0;
        chk("R7 irq low after ack", irq, 0);
        chk("R7 vec held", vec, 6);
        chk("R8 gie cleared", gie, 0);
        chk("R10 multi kept", flags, 8'h48);
        step();
        chk("R8 no irq while disabled", irq, 0);
        do_reti();
        chk("R9 gie restored", gie, 1);
        chk("R6 same winner again", vec, 6);
        pulse_clr(8'h40);
        chk("R6 next winner", vec, 3);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R10 single cleared", flags, 8'h00);
        do_reti();
        chk("R9 gie back", gie, 1);
        chk("R10 nothing left", irq, 0);
    endtask

    task automatic t_nmi();
        write_gie(1'b0);
        src_en = 8'h00;
        pulse_evt(8'h80);
        chk("R3 masked flag", irq, 0);
        nmi = 1'b1; step(); nmi = 1'b0;
        chk("R5 nmi irq", irq, 1);
        chk("R5 nmi vec", vec, 8);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R7 nmi vec held", vec, 8);
        step();
        chk("R10 nmi pending cleared", irq, 0);
        do_reti();
        chk("R9 restored low", gie, 0);
        src_en = 8'hFF;
        write_gie(1'b1);
        chk("R6 src7", vec, 7);
        nmi = 1'b1; step(); nmi = 1'b0;
        chk("R5 nmi beats maskable", vec, 8);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R8 gie cleared by nmi", gie, 0);
        do_reti();
        chk("R9 restored high", gie, 1);
        chk("R10 multi flag left", vec, 7);
    endtask

    initial begin
        rst_n = 1'b0; src_evt = '0; src_clr = '0; src_en = '0;
        nmi = 1'b0; gie_wr = 1'b0; gie_val = 1'b0; ack = 1'b0; reti = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_flags();
        t_gating();
        t_priority();
        t_nmi();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule